// File: doc/BRIEF.md
# Software Interrupt Request Register

This block holds one request flag for each of seven interrupt priority levels. Software raises requests by writing a 16-bit word. The block finds the highest pending level and reports it in three ways. It appears twice inside the readable word. It drives a level output for an external arbiter. It drives an interrupt line that is compared against the processor's current priority.

When the core acknowledges an interrupt, it gives the serviced level. The matching flag is cleared, and the reported level falls to the next pending one, or to zero. Reads are combinational and can be a full word or a single byte. Writes are always full words.

The arbiter and the vector generation sit outside this block.

Top module: `soft_irq_reg`

## Requirements
- R1: On a word write, only bits 15:9 of the written data are stored. Every other written bit is dropped, so reading any other bit can never show a written value.
- R2: Bit 9+k holds the request for level k+1, for k from 0 to 6. `req_lvl_o` gives the highest level whose flag is set, or 0 when no flag is set.
- R3: A word read (`rd_byte_i`=0) returns the following word. Bits 15:9 are the request flags. Bits 7:5 and bits 3:1 both carry the highest pending level. Bits 8, 4 and 0 are zero.
- R4: A byte read (`rd_byte_i`=1) places the selected byte in bits 7:0 and zeroes bits 15:8. With `rd_hi_i`=0 (the even address) the selected byte is word bits 7:0. With `rd_hi_i`=1 (the odd address) it is word bits 15:8.
- R5: After the clock edge that stores a write or an acknowledge, every output reflects the new flags. The read data and the level are derived combinationally from the stored flags.
- R6: An acknowledge (`ack_i`=1) with level L from 1 to 7 clears the flag for level L and leaves the other flags unchanged.
- R7: An acknowledge with level 0 changes nothing. If a write and an acknowledge happen in the same cycle, the written flags are stored first and the acknowledged flag is then cleared from them.
- R8: `irq_o` is 1 exactly when the highest pending level is greater than `cur_pri_i`.
- R9: An active-low reset clears all request flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Word write strobe |
| wr_data_i | input | 16 | Write data |
| rd_byte_i | input | 1 | 1 selects a byte read, 0 selects a word read |
| rd_hi_i | input | 1 | Byte select for a byte read: 1 is the odd byte, 0 is the even byte |
| rd_data_o | output | 16 | Read data |
| ack_i | input | 1 | Interrupt acknowledge strobe |
| ack_lvl_i | input | 3 | Level being acknowledged |
| cur_pri_i | input | 3 | Current processor priority |
| req_lvl_o | output | 3 | Highest pending level |
| irq_o | output | 1 | Interrupt request |

## Verification
The properties assume that the inputs are stable around the clock edge. The write-masking property only looks at read data in cycles that follow a plain write, and only when a word read is selected. Because of this, the bench holds `rd_byte_i` at 0 for most of the run and switches it only inside the byte-read phase. Acknowledges carry every level from 0 to 7, including levels whose flag is not set and a write in the same cycle. Every cycle is compared against a behavioural model of the flags.

// File: rtl/soft_irq_pkg.sv
package soft_irq_pkg;
  parameter int unsigned DATA_W  = 16;
  parameter int unsigned NUM_LVL = 7;
  parameter int unsigned LVL_W   = $clog2(NUM_LVL + 1);
  parameter int unsigned REQ_LSB = DATA_W - NUM_LVL;
endpackage

// File: rtl/soft_irq_prio_enc.sv
module soft_irq_prio_enc #(
  parameter int unsigned NUM_LVL = 7,
  parameter int unsigned LVL_W   = $clog2(NUM_LVL + 1)
) (
  input  logic [NUM_LVL-1:0] req_i,
  output logic [LVL_W-1:0]   lvl_o
);
  // last hit wins: highest index dominates
  always_comb begin
    lvl_o = '0;
    for (int i = 0; i < NUM_LVL; i++) begin
      if (req_i[i]) lvl_o = LVL_W'(i + 1);
    end
  end
endmodule

// File: rtl/soft_irq_rd_fmt.sv
module soft_irq_rd_fmt #(
  parameter int unsigned DATA_W  = 16,
  parameter int unsigned NUM_LVL = 7,
  parameter int unsigned LVL_W   = 3
) (
  input  logic [NUM_LVL-1:0] req_i,
  input  logic [LVL_W-1:0]   lvl_i,
  input  logic               rd_byte_i,
  input  logic               rd_hi_i,
  output logic [DATA_W-1:0]  rd_data_o
);
  localparam int unsigned REQ_LSB = DATA_W - NUM_LVL;
  localparam int unsigned BYTE_W  = DATA_W / 2;
  localparam int unsigned ID_LO   = 1;
  localparam int unsigned ID_HI   = ID_LO + LVL_W + 1;

  logic [DATA_W-1:0] word;

  always_comb begin
    word = '0;
    word[DATA_W-1:REQ_LSB]    = req_i;
    word[ID_LO +: LVL_W]      = lvl_i;
    word[ID_HI +: LVL_W]      = lvl_i;
  end

  always_comb begin
    if (!rd_byte_i)   rd_data_o = word;
    else if (rd_hi_i) rd_data_o = {{BYTE_W{1'b0}}, word[DATA_W-1:BYTE_W]};
    else              rd_data_o = {{BYTE_W{1'b0}}, word[BYTE_W-1:0]};
  end
endmodule

// File: rtl/soft_irq_reg.sv
module soft_irq_reg
  import soft_irq_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              rd_byte_i,
  input  logic              rd_hi_i,
  output logic [DATA_W-1:0] rd_data_o,
  input  logic              ack_i,
  input  logic [LVL_W-1:0]  ack_lvl_i,
  input  logic [LVL_W-1:0]  cur_pri_i,
  output logic [LVL_W-1:0]  req_lvl_o,
  output logic              irq_o
);
  logic [NUM_LVL-1:0] req_q, req_d, ack_mask;

  always_comb begin
    ack_mask = '0;
    if (ack_i && ack_lvl_i != '0) ack_mask[ack_lvl_i - LVL_W'(1)] = 1'b1;
  end

  // write lands first, ack then strips its bit
  always_comb begin
    req_d = wr_en_i ? wr_data_i[DATA_W-1:REQ_LSB] : req_q;
    req_d = req_d & ~ack_mask;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) req_q <= '0;
    else         req_q <= req_d;
  end

  soft_irq_prio_enc #(.NUM_LVL(NUM_LVL), .LVL_W(LVL_W)) u_enc (
    .req_i (req_q),
    .lvl_o (req_lvl_o)
  );

  soft_irq_rd_fmt #(.DATA_W(DATA_W), .NUM_LVL(NUM_LVL), .LVL_W(LVL_W)) u_fmt (
    .req_i     (req_q),
    .lvl_i     (req_lvl_o),
    .rd_byte_i (rd_byte_i),
    .rd_hi_i   (rd_hi_i),
    .rd_data_o (rd_data_o)
  );

  assign irq_o = req_lvl_o > cur_pri_i;
endmodule

// File: rtl/soft_irq_reg_chk.sv
module soft_irq_reg_chk
  import soft_irq_pkg::*;
(
  input logic              clk_i,
  input logic              rst_ni,
  input logic              wr_en_i,
  input logic [DATA_W-1:0] wr_data_i,
  input logic              rd_byte_i,
  input logic [DATA_W-1:0] rd_data_o,
  input logic              ack_i,
  input logic [LVL_W-1:0]  ack_lvl_i,
  input logic [LVL_W-1:0]  req_lvl_o,
  input logic              irq_o
);
  AST_WRITE_MASK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && !ack_i) |=> (rd_byte_i || rd_data_o[DATA_W-1:REQ_LSB] == $past(wr_data_i[DATA_W-1:REQ_LSB]))); // R1

  AST_ID_COPIES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_byte_i |-> (rd_data_o[3:1] == req_lvl_o && rd_data_o[7:5] == req_lvl_o)); // R3

  AST_ZERO_BITS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_byte_i |-> (rd_data_o[8] == 1'b0 && rd_data_o[4] == 1'b0 && rd_data_o[0] == 1'b0)); // R3

  AST_BYTE_UPPER: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_byte_i |-> rd_data_o[DATA_W-1:DATA_W/2] == '0); // R4

  AST_ACK_DROPS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_i && !wr_en_i && ack_lvl_i != '0) |=> req_lvl_o != $past(ack_lvl_i)); // R6

  AST_IDLE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_lvl_o == '0 |-> !irq_o); // R8
endmodule

bind soft_irq_reg soft_irq_reg_chk u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .wr_en_i   (wr_en_i),
  .wr_data_i (wr_data_i),
  .rd_byte_i (rd_byte_i),
  .rd_data_o (rd_data_o),
  .ack_i     (ack_i),
  .ack_lvl_i (ack_lvl_i),
  .req_lvl_o (req_lvl_o),
  .irq_o     (irq_o)
);

// File: tb/soft_irq_reg_test.sv
module soft_irq_reg_test;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        wr_en_i = 1'b0;
  logic [15:0] wr_data_i = '0;
  logic        rd_byte_i = 1'b0;
  logic        rd_hi_i = 1'b0;
  logic [15:0] rd_data_o;
  logic        ack_i = 1'b0;
  logic [2:0]  ack_lvl_i = '0;
  logic [2:0]  cur_pri_i = '0;
  logic [2:0]  req_lvl_o;
  logic        irq_o;

  int    n_tests = 0;
  int    n_fail  = 0;
  bit    done    = 1'b0;
  string cur_req = "R9";
  bit [6:0] m_req = '0;

  always #4 clk_i = ~clk_i;

  soft_irq_reg uut (.*);

  function automatic int exp_lvl();
    int l = 0;
    for (int i = 0; i < 7; i++) if (m_req[i]) l = i + 1;
    return l;
  endfunction

  function automatic logic [15:0] exp_word();
    int l = exp_lvl();
    return (16'(m_req) << 9) | (16'(l) << 5) | (16'(l) << 1);
  endfunction

  task automatic chk(string req, logic [15:0] act, logic [15:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic compare();
    logic [15:0] w = exp_word();
    logic [15:0] e;
    if (!rd_byte_i)   e = w;
    else if (rd_hi_i) e = {8'h00, w[15:8]};
    else              e = {8'h00, w[7:0]};
    chk({cur_req, " rd_data"}, rd_data_o, e);
    chk({cur_req, " lvl R2"}, 16'(req_lvl_o), 16'(exp_lvl()));
    chk({cur_req, " irq R8"}, 16'(irq_o), 16'(exp_lvl() > int'(cur_pri_i)));
  endtask

  // model update at edge, compare mid-cycle
  task automatic step();
    @(posedge clk_i);
    if (!rst_ni) m_req = '0;
    else begin
      if (wr_en_i) m_req = wr_data_i[15:9];
      if (ack_i && ack_lvl_i != 0) m_req[ack_lvl_i - 1] = 1'b0;
    end
    @(negedge clk_i);
    compare();
    wr_en_i = 1'b0;
    ack_i = 1'b0;
  endtask

  task automatic do_wr(logic [15:0] d);
    wr_en_i = 1'b1; wr_data_i = d; step();
  endtask

  task automatic do_ack(int l);
    ack_i = 1'b1; ack_lvl_i = 3'(l); step();
  endtask

  initial begin
    #(8 * 20000);
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog: actual hung expected done");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    @(negedge clk_i);
    cur_req = "R9"; compare();
    step(); step();
    rst_ni = 1'b1;
    step();

    cur_req = "R1"; do_wr(16'h01FF); do_wr(16'hFFFF); do_wr(16'h0000);
    cur_req = "R2";
    for (int k = 0; k < 7; k++) do_wr(16'(1) << (9 + k));
    do_wr(16'h0A00); do_wr(16'h5400);
    cur_req = "R3"; do_wr(16'hB600); step();
    cur_req = "R4"; rd_byte_i = 1'b1;
    rd_hi_i = 1'b0; step(); rd_hi_i = 1'b1; step();
    do_wr(16'h0200); rd_hi_i = 1'b0; step();
    rd_byte_i = 1'b0; rd_hi_i = 1'b0;

    cur_req = "R5"; do_wr(16'h8000);
    chk("R5 level right after write", 16'(req_lvl_o), 16'd7);

    cur_req = "R6"; do_wr(16'hFE00);
    for (int l = 7; l >= 1; l--) do_ack(l);
    chk("R6 all cleared", rd_data_o, 16'h0000);
    do_wr(16'h2A00); do_ack(5); do_ack(2); do_ack(4);

    cur_req = "R7"; do_wr(16'h4400); do_ack(0);
    chk("R7 ack0 no effect", rd_data_o, 16'h44CC);
    wr_en_i = 1'b1; wr_data_i = 16'hC000; ack_i = 1'b1; ack_lvl_i = 3'd7; step();
    chk("R7 write then ack", rd_data_o, 16'h40CC);

    cur_req = "R8"; do_wr(16'h0800);
    for (int p = 0; p < 8; p++) begin cur_pri_i = 3'(p); step(); end
    cur_pri_i = 3'd0; do_wr(16'h0000); step();

    cur_req = "R9"; do_wr(16'hFE00);
    rst_ni = 1'b0; #1;
    chk("R9 async clear", rd_data_o, 16'h0000);
    step(); rst_ni = 1'b1; step();

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule